// File: doc/BRIEF.md
# Sleep and wake-up controller

This block keeps the three low-power control bits of a processor subsystem and decides when the subsystem must be woken. One bit inhibits the processor bus clock, one disables the PLL and one disables the RF reference clock input. Software sets these bits through a small write port. The clock gating cells and the PLL are outside this block. The watchdog and the secondary UART run from their own UART clock, so inhibiting the bus clock does not stop them. They can therefore still raise wake requests.

Eight level-type wake sources enter through a two-flop synchronizer: tick, supply failure, RTC compare match, correlator accumulate, correlator measurement, UART receive activity, discrete input and watchdog warning. Each synchronized source is qualified by its own masking rule. A qualified source that arrives while any sleep bit is set drives the active-low sleep-reset line low for one clock. In that same clock, all three sleep bits are cleared. Downstream logic treats the falling edge of the sleep-reset line as the wake-up event.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset all three sleep outputs are 0 and `slp_rst_n` is 1.
- R2: A write (`wr_en`=1) loads `wr_sleep` into the sleep outputs on the next clock edge. Bit 0 drives `bus_clk_inhibit`, bit 1 drives `pll_disable` and bit 2 drives `rf_ref_disable`.
- R3: When an enabled wake source rises while any sleep bit is set, `slp_rst_n` goes low on the third clock edge after the rise (two synchronizer flops, then one register). It stays low for exactly one clock, and all three sleep outputs are 0 from that same edge.
- R4: A source whose enable is 0 has no effect: the sleep outputs keep their value and `slp_rst_n` stays 1.
- R5: When no sleep bit is set, an enabled wake source produces no pulse on `slp_rst_n`.
- R6: The correlator accumulate and correlator measurement sources share the single enable `en_corr`. Tick, RTC, UART and discrete sources each have their own enable.
- R7: The watchdog warning source wakes whenever `wdog_en`=1, whatever the other enables are. With `wdog_en`=0 it is ignored.
- R8: The supply-failure source wakes only when `en_pwr_fail`=1 and `pgood_shdn_en`=0.
- R9: If a wake and a write fall on the same clock edge while a sleep bit is set, the wake wins: the sleep outputs become 0 and the written value is dropped.
- R10: A source that stays high after a wake gives no further pulse as long as the sleep bits remain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | Tick interrupt wake source |
| src_pwr_fail | input | 1 | Supply failure wake source |
| src_rtc_match | input | 1 | RTC compare match wake source |
| src_accum | input | 1 | Correlator accumulate interrupt |
| src_meas | input | 1 | Correlator measurement interrupt |
| src_uart_rx | input | 1 | UART receive activity |
| src_disc | input | 1 | Discrete input, active high |
| src_wdog_warn | input | 1 | Watchdog warning interrupt |
| en_tick | input | 1 | Enables the tick wake |
| en_pwr_fail | input | 1 | Enables the supply failure wake |
| en_rtc | input | 1 | Enables the RTC wake |
| en_corr | input | 1 | Enables both correlator wakes |
| en_uart | input | 1 | Enables the UART wake |
| en_disc | input | 1 | Enables the discrete input wake |
| wdog_en | input | 1 | Watchdog enable; also gates the watchdog wake |
| pgood_shdn_en | input | 1 | Power-good shutdown enable; blocks the supply failure wake when 1 |
| wr_en | input | 1 | Write strobe for the sleep bits |
| wr_sleep | input | 3 | Sleep bit values to write |
| bus_clk_inhibit | output | 1 | Inhibits the processor bus clock |
| pll_disable | output | 1 | Disables the PLL |
| rf_ref_disable | output | 1 | Disables the RF reference input |
| slp_rst_n | output | 1 | Sleep-reset line; a falling edge is the wake-up event |

## Verification
Each of the eight sources is raised on its own, first with its enable set and then with it clear. This shows that every source reaches the wake logic and that no enable is wired to the wrong source. The watchdog and supply-failure sources are also tried under every combination of their controlling bits, which separates their special rules from ordinary masking. Sources are raised with no sleep bit set, held high after a wake, and timed to meet a write on the same edge. These cases separate a correct one-clock pulse from a level-following output and from a write that wrongly wins. Varied sleep-bit patterns confirm that every bit is cleared.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;
  localparam int unsigned NSRC = 8;
  localparam int unsigned NSLP = 3;

  localparam int unsigned SRC_TICK  = 0;
  localparam int unsigned SRC_PWR   = 1;
  localparam int unsigned SRC_RTC   = 2;
  localparam int unsigned SRC_ACCUM = 3;
  localparam int unsigned SRC_MEAS  = 4;
  localparam int unsigned SRC_UART  = 5;
  localparam int unsigned SRC_DISC  = 6;
  localparam int unsigned SRC_WDOG  = 7;

  localparam int unsigned SLP_BUS = 0;
  localparam int unsigned SLP_PLL = 1;
  localparam int unsigned SLP_RF  = 2;

  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [NSLP-1:0] slp_vec_t;
endpackage

// File: rtl/slpwk_sync.sv
module slpwk_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_d;
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = async_i;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/slpwk_wake_mask.sv
module slpwk_wake_mask
  import slpwk_pkg::*;
(
  input  src_vec_t src_sync,
  input  logic     en_tick,
  input  logic     en_pwr_fail,
  input  logic     en_rtc,
  input  logic     en_corr,
  input  logic     en_uart,
  input  logic     en_disc,
  input  logic     wdog_en,
  input  logic     pgood_shdn_en,
  output logic     wake_req
);
  src_vec_t allow;

  always_comb begin
    allow            = '0;
    allow[SRC_TICK]  = en_tick;
    // supply-fail wake only counts while power-good shutdown is off
    allow[SRC_PWR]   = en_pwr_fail & ~pgood_shdn_en;
    allow[SRC_RTC]   = en_rtc;
    allow[SRC_ACCUM] = en_corr;
    allow[SRC_MEAS]  = en_corr;
    allow[SRC_UART]  = en_uart;
    allow[SRC_DISC]  = en_disc;
    // watchdog warning has no mask of its own
    allow[SRC_WDOG]  = wdog_en;
  end

  assign wake_req = |(src_sync & allow);
endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
  import slpwk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wake_req,
  input  logic     wr_en,
  input  slp_vec_t wr_sleep,
  output slp_vec_t sleep_o,
  output logic     slp_rst_n_o
);
  slp_vec_t sleep_q, sleep_d;
  logic     slp_rst_n_q, slp_rst_n_d;
  logic     wake_fire;

  assign wake_fire = wake_req & (|sleep_q);

  always_comb begin
    sleep_d     = sleep_q;
    slp_rst_n_d = 1'b1;
    if (wake_fire) begin
      sleep_d     = '0;
      slp_rst_n_d = 1'b0;
    end else if (wr_en) begin
      sleep_d = wr_sleep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q     <= '0;
      slp_rst_n_q <= 1'b1;
    end else begin
      sleep_q     <= sleep_d;
      slp_rst_n_q <= slp_rst_n_d;
    end
  end

  assign sleep_o     = sleep_q;
  assign slp_rst_n_o = slp_rst_n_q;

  a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_rst_n_q |=> slp_rst_n_q);
  a_r3_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_rst_n_q |-> (sleep_q == '0));
  a_r5_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_rst_n_q |-> $past(|sleep_q));
  a_r4_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !wake_req) |=> $stable(sleep_q));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import slpwk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_tick,
  input  logic       src_pwr_fail,
  input  logic       src_rtc_match,
  input  logic       src_accum,
  input  logic       src_meas,
  input  logic       src_uart_rx,
  input  logic       src_disc,
  input  logic       src_wdog_warn,
  input  logic       en_tick,
  input  logic       en_pwr_fail,
  input  logic       en_rtc,
  input  logic       en_corr,
  input  logic       en_uart,
  input  logic       en_disc,
  input  logic       wdog_en,
  input  logic       pgood_shdn_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sleep,
  output logic       bus_clk_inhibit,
  output logic       pll_disable,
  output logic       rf_ref_disable,
  output logic       slp_rst_n
);
  src_vec_t src_raw, src_sync;
  slp_vec_t sleep_bits;
  logic     wake_req;

  always_comb begin
    src_raw            = '0;
    src_raw[SRC_TICK]  = src_tick;
    src_raw[SRC_PWR]   = src_pwr_fail;
    src_raw[SRC_RTC]   = src_rtc_match;
    src_raw[SRC_ACCUM] = src_accum;
    src_raw[SRC_MEAS]  = src_meas;
    src_raw[SRC_UART]  = src_uart_rx;
    src_raw[SRC_DISC]  = src_disc;
    src_raw[SRC_WDOG]  = src_wdog_warn;
  end

  slpwk_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_raw),
    .sync_o  (src_sync)
  );

  slpwk_wake_mask i_mask (
    .src_sync      (src_sync),
    .en_tick       (en_tick),
    .en_pwr_fail   (en_pwr_fail),
    .en_rtc        (en_rtc),
    .en_corr       (en_corr),
    .en_uart       (en_uart),
    .en_disc       (en_disc),
    .wdog_en       (wdog_en),
    .pgood_shdn_en (pgood_shdn_en),
    .wake_req      (wake_req)
  );

  slpwk_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_req    (wake_req),
    .wr_en       (wr_en),
    .wr_sleep    (wr_sleep),
    .sleep_o     (sleep_bits),
    .slp_rst_n_o (slp_rst_n)
  );

  assign bus_clk_inhibit = sleep_bits[SLP_BUS];
  assign pll_disable     = sleep_bits[SLP_PLL];
  assign rf_ref_disable  = sleep_bits[SLP_RF];

  a_r7_wdog_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sync[SRC_WDOG] && wdog_en && (|sleep_bits)) |=> !slp_rst_n);
  a_r8_pgood_blocks_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood_shdn_en && (src_sync & ~(src_vec_t'(1) << SRC_PWR)) == '0)
      |=> slp_rst_n);
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] src = '0;
  logic [5:0] en = '0;
  logic wdog_en = 1'b0;
  logic pgood_shdn_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sleep = '0;
  logic bus_clk_inhibit, pll_disable, rf_ref_disable, slp_rst_n;
  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl i_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n),
    .src_tick(src[0]), .src_pwr_fail(src[1]), .src_rtc_match(src[2]),
    .src_accum(src[3]), .src_meas(src[4]), .src_uart_rx(src[5]),
    .src_disc(src[6]), .src_wdog_warn(src[7]),
    .en_tick(en[0]), .en_pwr_fail(en[1]), .en_rtc(en[2]), .en_corr(en[3]),
    .en_uart(en[4]), .en_disc(en[5]),
    .wdog_en(wdog_en), .pgood_shdn_en(pgood_shdn_en),
    .wr_en(wr_en), .wr_sleep(wr_sleep),
    .bus_clk_inhibit(bus_clk_inhibit), .pll_disable(pll_disable),
    .rf_ref_disable(rf_ref_disable), .slp_rst_n(slp_rst_n)
  );

  function automatic logic [2:0] sleep_now();
    return {rf_ref_disable, pll_disable, bus_clk_inhibit};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic write_sleep(input logic [2:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sleep = v;
    tick(1);
    wr_en = 1'b0;
    check("R2 write", {slp_rst_n, sleep_now()}, {1'b1, v});
  endtask

  // raise one source with sleep bits set; expect wake or no wake
  task automatic wake_case(input int idx, input logic exp_wake, input string req);
    write_sleep(3'b111);
    @(negedge clk);
    src[idx] = 1'b1;
    tick(2);
    check({req, " before latency"}, {slp_rst_n, sleep_now()}, 4'b1111);
    tick(1);
    if (exp_wake) check(req, {slp_rst_n, sleep_now()}, 4'b0000);
    else          check({req, " ignored"}, {slp_rst_n, sleep_now()}, 4'b1111);
    tick(1);
    check({req, " after"}, {slp_rst_n, sleep_now()}, exp_wake ? 4'b1000 : 4'b1111);
    @(negedge clk);
    src[idx] = 1'b0;
    tick(3);
    if (!exp_wake) write_sleep(3'b000);
  endtask

  task automatic t_reset();
    check("R1 reset", {slp_rst_n, sleep_now()}, 4'b1000);
  endtask

  task automatic t_write_patterns();
    write_sleep(3'b001);
    write_sleep(3'b010);
    write_sleep(3'b100);
    write_sleep(3'b000);
  endtask

  task automatic t_each_source();
    en = 6'b111111; wdog_en = 1'b1; pgood_shdn_en = 1'b0;
    for (int s = 0; s < 8; s++) wake_case(s, 1'b1, "R3 enabled source wakes");
    en = '0; wdog_en = 1'b0;
    for (int s = 0; s < 8; s++) wake_case(s, 1'b0, "R4 masked source");
  endtask

  task automatic t_corr_shared();
    en = 6'b001000;
    wake_case(3, 1'b1, "R6 accum via en_corr");
    wake_case(4, 1'b1, "R6 meas via en_corr");
    wake_case(0, 1'b0, "R6 tick not on en_corr");
    en = 6'b110111;
    wake_case(3, 1'b0, "R6 accum blocked");
    wake_case(4, 1'b0, "R6 meas blocked");
    en = '0;
  endtask

  task automatic t_wdog();
    en = '0; wdog_en = 1'b1;
    wake_case(7, 1'b1, "R7 wdog wake with other enables off");
    wdog_en = 1'b0; en = 6'b111111;
    wake_case(7, 1'b0, "R7 wdog off");
    en = '0;
  endtask

  task automatic t_pwr();
    en = 6'b000010; pgood_shdn_en = 1'b1;
    wake_case(1, 1'b0, "R8 shutdown enable blocks");
    pgood_shdn_en = 1'b0;
    wake_case(1, 1'b1, "R8 pwr fail wake");
    en = '0;
    wake_case(1, 1'b0, "R8 pwr fail disabled");
  endtask

  task automatic t_idle_and_hold();
    en = 6'b000001;
    write_sleep(3'b000);
    @(negedge clk);
    src[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      check("R5 no pulse when awake", {slp_rst_n, sleep_now()}, 4'b1000);
    end
    @(negedge clk);
    src[0] = 1'b0;
    tick(3);
    write_sleep(3'b110);
    @(negedge clk);
    src[0] = 1'b1;
    tick(3);
    check("R3 wake partial pattern", {slp_rst_n, sleep_now()}, 4'b0000);
    for (int i = 0; i < 5; i++) begin
      tick(1);
      check("R10 no repeat pulse", {slp_rst_n, sleep_now()}, 4'b1000);
    end
    @(negedge clk);
    src[0] = 1'b0;
    tick(3);
    en = '0;
  endtask

  task automatic t_coincide();
    en = 6'b100000;
    write_sleep(3'b101);
    @(negedge clk);
    src[6] = 1'b1;
    tick(2);
    wr_en = 1'b1; wr_sleep = 3'b111;
    tick(1);
    wr_en = 1'b0;
    check("R9 wake beats write", {slp_rst_n, sleep_now()}, 4'b0000);
    tick(1);
    check("R9 after", {slp_rst_n, sleep_now()}, 4'b1000);
    @(negedge clk);
    src[6] = 1'b0;
    tick(3);
    en = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_write_patterns();
    t_each_source();
    t_corr_shared();
    t_wdog();
    t_pwr();
    t_idle_and_hold();
    t_coincide();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule